// File: doc/BRIEF.md
# Selectable Ratio Clock Divider

This block turns a reference clock into a slower clock. A two-bit select input picks one of four integer ratios. Two of the ratios are odd and two are even. Alongside the primary divided clock it produces a companion clock at exactly half the primary frequency. The companion is toggled by the same reference rising edge that raises the primary, so the two stay aligned with no skew between them.

Odd ratios keep a 50% duty cycle. A phase built on the rising edge is stretched by half a reference cycle, using a copy of that phase retimed on the falling edge. Even ratios need no such correction.

A power-down input forces both outputs low at once and holds the counters cleared. An output-enable input releases both outputs to high impedance. After power-down is released, or after a ratio change, the outputs resume cleanly with no shortened pulses.

Top module: `clk_ratio_div`

## Requirements
- R1: The primary clock repeats every N reference cycles. N is 3, 5, 6 or 10 for `ratio_sel` values 0, 1, 2 and 3 respectively.
- R2: Each primary high pulse lasts exactly N reference half-cycles, and each low interval also lasts N half-cycles. This holds for odd N as well as even N.
- R3: The companion clock toggles on the same reference rising edge as every rising edge of the primary. It therefore starts low and stays high for 2N half-cycles and low for 2N half-cycles.
- R4: While `pwr_dn` is high and `out_en` is high, both outputs read low from the moment it rises. The counter and the companion are cleared on every reference rising edge during that time.
- R5: Count the reference rising edges that sample `pwr_dn` low, calling the first of them edge 1. The primary and the companion both rise on edge number N - floor(N/2).
- R6: `ratio_sel` is sampled only on the reference rising edge that falls inside the first reference cycle of a primary period. Across a change of ratio, every primary high pulse lasts exactly N_old or N_new half-cycles. The low interval that spans the switch is within one half-cycle of N_old or N_new. After that interval, all pulses use N_new.
- R7: While `out_en` is low, both outputs are high impedance, whatever the other inputs are doing.
- R8: Driving `rst_n` low clears the block asynchronously. Both outputs then read low while `out_en` is high.
- R9: The internal cycle counter always stays below the active ratio, so no period ever runs longer than N reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; both of its edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Ratio select: 0 gives 3, 1 gives 5, 2 gives 6, 3 gives 10 |
| pwr_dn | input | 1 | Power-down: holds both outputs low and clears the counter |
| out_en | input | 1 | Output enable; when low, both outputs are high impedance |
| clk_pri | output | 1 | Primary divided clock |
| clk_half | output | 1 | Companion clock at half the primary frequency |

## Verification
The assertions assume that `pwr_dn` and `ratio_sel` change away from the reference rising edge, so that each rising edge sees a settled value. The bench meets this by driving every input one time unit after a clock edge. The assertions also assume that the active ratio was loaded through the select path or by reset, so it is always one of the four parameterised values. Random select values and random mid-run ratio changes are applied only at those offset points, and `pwr_dn` is applied for several whole cycles before it is released, so the counter-reload and companion-toggle properties see clean cycles.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Largest of the four ratios; sizes the counter.
  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Counter value at which the rising-edge phase goes high: N - floor(N/2).
  function automatic int unsigned rise_point(input int unsigned n);
    return n - (n / 2);
  endfunction

endpackage

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO0 = 3,
  parameter int unsigned RATIO1 = 5,
  parameter int unsigned RATIO2 = 6,
  parameter int unsigned RATIO3 = 10,
  parameter int unsigned CNT_W  = 4
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] ratio,
  output logic             phase_hi,
  output logic             rise_evt,
  output logic             odd_mode
);

  logic [CNT_W-1:0] sel_ratio;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] rise_pt;
  logic             wrap;
  logic             phase_nxt;

  always_comb begin
    unique case (sel)
      2'd0:    sel_ratio = CNT_W'(RATIO0);
      2'd1:    sel_ratio = CNT_W'(RATIO1);
      2'd2:    sel_ratio = CNT_W'(RATIO2);
      default: sel_ratio = CNT_W'(RATIO3);
    endcase
  end

  assign rise_pt   = CNT_W'(rise_point(32'(ratio)));
  assign wrap      = (cnt == ratio - 1'b1);
  assign cnt_nxt   = (hold || wrap) ? '0 : cnt + 1'b1;
  assign phase_nxt = !hold && (cnt_nxt >= rise_pt);
  assign rise_evt  = !hold && (cnt_nxt == rise_pt);
  assign odd_mode  = ratio[0];

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      ratio    <= CNT_W'(RATIO0);
      phase_hi <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      phase_hi <= phase_nxt;
      if (cnt == '0) ratio <= sel_ratio;
    end
  end

endmodule

// File: rtl/clkdiv_oddfix.sv
module clkdiv_oddfix (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic phase_hi,
  input  logic odd_mode,
  output logic pri_core
);

  logic tail_q;

  // Falling-edge copy stretches the high phase by half a reference cycle.
  always_ff @(negedge clk_ref or negedge rst_n) begin
    if (!rst_n) tail_q <= 1'b0;
    else        tail_q <= phase_hi & odd_mode;
  end

  assign pri_core = phase_hi | tail_q;

endmodule

// File: rtl/clkdiv_half.sv
module clkdiv_half (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic hold,
  input  logic rise_evt,
  output logic half_core
);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)        half_core <= 1'b0;
    else if (hold)     half_core <= 1'b0;
    else if (rise_evt) half_core <= ~half_core;
  end

endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO0 = 3,
  parameter int unsigned RATIO1 = 5,
  parameter int unsigned RATIO2 = 6,
  parameter int unsigned RATIO3 = 10
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  input  logic       pwr_dn,
  input  logic       out_en,
  output wire        clk_pri,
  output wire        clk_half
);

  localparam int unsigned MAX_RATIO = max_of4(RATIO0, RATIO1, RATIO2, RATIO3);
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO + 1);

  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] ratio_w;
  logic             phase_w;
  logic             rise_w;
  logic             odd_w;
  logic             pri_core;
  logic             half_core;

  clkdiv_counter #(
    .RATIO0(RATIO0), .RATIO1(RATIO1), .RATIO2(RATIO2), .RATIO3(RATIO3), .CNT_W(CNT_W)
  ) u_cnt (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .hold    (pwr_dn),
    .sel     (ratio_sel),
    .cnt     (cnt_w),
    .ratio   (ratio_w),
    .phase_hi(phase_w),
    .rise_evt(rise_w),
    .odd_mode(odd_w)
  );

  clkdiv_oddfix u_odd (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .phase_hi(phase_w),
    .odd_mode(odd_w),
    .pri_core(pri_core)
  );

  clkdiv_half u_half (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .hold     (pwr_dn),
    .rise_evt (rise_w),
    .half_core(half_core)
  );

  assign clk_pri  = out_en ? (pri_core  & ~pwr_dn) : 1'bz;
  assign clk_half = out_en ? (half_core & ~pwr_dn) : 1'bz;

endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker #(
  parameter int unsigned RATIO0 = 3,
  parameter int unsigned RATIO1 = 5,
  parameter int unsigned RATIO2 = 6,
  parameter int unsigned RATIO3 = 10,
  parameter int unsigned CNT_W  = 4
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             pwr_dn,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ratio,
  input logic             phase_hi,
  input logic             rise_evt,
  input logic             half_core
);

  assert_cnt_below_ratio_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cnt < ratio);

  assert_ratio_legal_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (ratio == CNT_W'(RATIO0)) || (ratio == CNT_W'(RATIO1)) ||
    (ratio == CNT_W'(RATIO2)) || (ratio == CNT_W'(RATIO3)));

  assert_ratio_at_boundary_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cnt != '0) |=> $stable(ratio));

  assert_pwrdn_clears_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pwr_dn |=> (cnt == '0) && !phase_hi && !half_core);

  assert_half_toggles_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rise_evt |=> (half_core != $past(half_core)));

  assert_half_steady_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!rise_evt && !pwr_dn) |=> $stable(half_core));

  assert_phase_rise_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(phase_hi) |-> $past(rise_evt));

endmodule

bind clk_ratio_div clkdiv_checker #(
  .RATIO0(RATIO0), .RATIO1(RATIO1), .RATIO2(RATIO2), .RATIO3(RATIO3), .CNT_W(CNT_W)
) u_chk (
  .clk_ref  (clk_ref),
  .rst_n    (rst_n),
  .pwr_dn   (pwr_dn),
  .cnt      (cnt_w),
  .ratio    (ratio_w),
  .phase_hi (phase_w),
  .rise_evt (rise_w),
  .half_core(half_core)
);

// File: tb/clk_ratio_div_bench.sv
module clk_ratio_div_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSAMP      = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sel;
  logic       pwr_dn;
  logic       out_en;
  wire        pri_w;
  wire        half_w;

  int n_checks = 0;
  int n_fail   = 0;

  logic pri_s  [0:NSAMP-1];
  logic half_s [0:NSAMP-1];
  int   rl     [0:127];
  logic rv     [0:127];

  pullup (pri_w);
  pullup (half_w);

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_ratio_div u_clk_ratio_div (
    .clk_ref  (clk),
    .rst_n    (rst_n),
    .ratio_sel(sel),
    .pwr_dn   (pwr_dn),
    .out_en   (out_en),
    .clk_pri  (pri_w),
    .clk_half (half_w)
  );

  // ---- expected values from the requirements ----
  function automatic int ratio_of(input logic [1:0] s);
    case (s)
      2'd0:    return 3;
      2'd1:    return 5;
      2'd2:    return 6;
      default: return 10;
    endcase
  endfunction

  // R5: rise on edge N - floor(N/2); two samples per reference cycle.
  function automatic int first_hi(input int n);
    return 2 * ((n - n / 2) - 1);
  endfunction

  function automatic logic exp_pri(input int n, input int idx);
    if (idx < first_hi(n)) return 1'b0;
    return ((idx - first_hi(n)) % (2 * n)) < n;
  endfunction

  function automatic logic exp_half(input int n, input int idx);
    if (idx < first_hi(n)) return 1'b0;
    return ((idx - first_hi(n)) % (4 * n)) < (2 * n);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hstep();
    @(clk);
    #1;
  endtask

  task automatic collect(input int start, input int n);
    for (int i = start; i < start + n; i++) begin
      hstep();
      pri_s[i]  = pri_w;
      half_s[i] = half_w;
    end
  endtask

  task automatic power_down_and_select(input logic [1:0] s);
    @(negedge clk);
    #1;
    pwr_dn = 1'b1;
    sel    = s;
    #1;
    check(pri_w == 1'b0 && half_w == 1'b0, "R4 immediate low", int'({pri_w, half_w}), 0);
    repeat (3) @(negedge clk);
    #1;
    check(pri_w == 1'b0 && half_w == 1'b0, "R4 held low", int'({pri_w, half_w}), 0);
  endtask

  // R3: companion equals parity of primary rising edges seen so far.
  task automatic check_half_parity(input int total, input string req);
    int   rises = 0;
    int   bad   = 0;
    logic prev  = 1'b0;
    for (int i = 0; i < total; i++) begin
      if (pri_s[i] && !prev) rises++;
      if (half_s[i] != rises[0]) bad++;
      prev = pri_s[i];
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic run_ratio(input logic [1:0] s);
    int n     = ratio_of(s);
    int total = first_hi(n) + 8 * n + 2;
    int bad_p = 0;
    int bad_h = 0;
    int r1    = -1;
    int r2    = -1;
    power_down_and_select(s);
    pwr_dn = 1'b0;
    collect(0, total);
    for (int i = 0; i < total; i++) begin
      if (pri_s[i]  != exp_pri(n, i))  bad_p++;
      if (half_s[i] != exp_half(n, i)) bad_h++;
      if (pri_s[i] && (i == 0 || !pri_s[i-1])) begin
        if (r1 < 0) r1 = i;
        else if (r2 < 0) r2 = i;
      end
    end
    check(r1 == first_hi(n), "R5 first rise sample", r1, first_hi(n));
    check(half_s[r1 < 0 ? 0 : r1] == 1'b1, "R5 companion rises with primary", 0, 1);
    check(r2 - r1 == 2 * n, "R1/R9 primary period", r2 - r1, 2 * n);
    check(bad_p == 0, "R2 primary high/low lengths", bad_p, 0);
    check(bad_h == 0, "R3 companion waveform", bad_h, 0);
  endtask

  task automatic run_change(input logic [1:0] a, input logic [1:0] b);
    int na    = ratio_of(a);
    int nb    = ratio_of(b);
    int pre   = first_hi(na) + 4 * na;
    int post  = 8 * na + 8 * nb;
    int total = pre + post;
    int nr    = 0;
    int len   = 1;
    int bad_hi = 0;
    int bad_lo = 0;
    int lo_min;
    int lo_max;
    logic prev;
    lo_min = ((na < nb) ? na : nb) - 1;
    lo_max = ((na > nb) ? na : nb) + 1;
    power_down_and_select(a);
    pwr_dn = 1'b0;
    collect(0, pre);
    sel = b;
    collect(pre, post);
    prev = pri_s[first_hi(na)];
    for (int i = first_hi(na) + 1; i < total; i++) begin
      if (pri_s[i] == prev) len++;
      else begin
        if (nr < 128) begin
          rl[nr] = len;
          rv[nr] = prev;
          nr++;
        end
        prev = pri_s[i];
        len  = 1;
      end
    end
    for (int k = 0; k < nr; k++) begin
      if (rv[k] && rl[k] != na && rl[k] != nb) bad_hi++;
      if (!rv[k] && (rl[k] < lo_min || rl[k] > lo_max)) bad_lo++;
    end
    check(bad_hi == 0, "R6 high pulse lengths across change", bad_hi, 0);
    check(bad_lo == 0, "R6 low interval bounds across change", bad_lo, 0);
    check(nr >= 2 && rl[nr-1] == nb && rl[nr-2] == nb, "R6 settles to new ratio",
          (nr >= 1) ? rl[nr-1] : -1, nb);
    check_half_parity(total, "R3 companion parity across change");
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd51423));
    rst_n  = 1'b0;
    pwr_dn = 1'b1;
    out_en = 1'b1;
    sel    = 2'd0;
    repeat (3) @(negedge clk);
    #1;
    check(pri_w == 1'b0 && half_w == 1'b0, "R8 reset state", int'({pri_w, half_w}), 0);
    rst_n = 1'b1;

    // Directed: every encoding of R1.
    for (int s = 0; s < 4; s++) run_ratio(2'(s));

    // R7: disabled outputs float (pulled up by bench), whatever the other inputs do.
    out_en = 1'b0;
    repeat (6) begin
      hstep();
      check(pri_w == 1'b1 && half_w == 1'b1, "R7 high impedance while running",
            int'({pri_w, half_w}), 3);
    end
    pwr_dn = 1'b1;
    #1;
    check(pri_w == 1'b1 && half_w == 1'b1, "R7 high impedance in power-down",
          int'({pri_w, half_w}), 3);
    out_en = 1'b1;
    #1;
    check(pri_w == 1'b0 && half_w == 1'b0, "R4 driven low once enabled",
          int'({pri_w, half_w}), 0);

    // R8: asynchronous reset in the middle of a high pulse.
    pwr_dn = 1'b0;
    sel    = 2'd3;
    repeat (20) hstep();
    wait (pri_w == 1'b1);
    #2;
    rst_n = 1'b0;
    #1;
    check(pri_w == 1'b0 && half_w == 1'b0, "R8 async reset clears outputs",
          int'({pri_w, half_w}), 0);
    @(negedge clk);
    #1;
    pwr_dn = 1'b1;
    rst_n  = 1'b1;

    // Random ratios and random mid-run ratio changes.
    for (int it = 0; it < 12; it++) run_ratio(2'($urandom % 4));
    for (int it = 0; it < 8; it++) run_change(2'($urandom % 4), 2'($urandom % 4));
    run_change(2'd3, 2'd0);
    run_change(2'd0, 2'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule